// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synchronous static memory whose read and write cycles can follow each other in any order, on every clock, with no idle cycle between them. Address and control are registered on the rising edge. Read data leaves through an edge-triggered output register. Write data follows its address by two clock edges. Because of that offset, the shared data bus carries the data of a read and of a write in the same position in the pipeline, so the two never collide.

A deferred write stays in a two-stage address pipeline until its data arrives. A read that hits such a pending address receives the new bytes straight from the data input. An advance input continues a four-beat burst, in linear or interleaved order, from the last loaded address. A clock enable freezes every register in the block. The output enable and sleep inputs remove the output drive at once, without waiting for a clock. The array is small (256 words of four 9-bit lanes by default), and a package holds its shape.

Top module: `zt_sram`

## Requirements
- R1: A load cycle (adv=0) is accepted only when sel_a=1, sel_b=1 and sel_c_n=0. Otherwise the cycle is a deselect: it writes nothing and causes no output drive.
- R2: A read accepted at edge n places the word on d_out at edge n+1, with d_oe=1 until edge n+2 (given oe_n=0 and sleep=0).
- R3: For a write accepted at edge n, the word on d_in at edge n+2 is stored. Lane l occupies data bits [9l+8:9l].
- R4: lane_wr[l]=1 at the address edge enables lane l of a write. A lane with lane_wr[l]=0 keeps its old contents.
- R5: Reads and writes may alternate on consecutive accepted cycles. A read of an address whose write data has not yet been stored returns the new bytes in the enabled lanes and the stored bytes in the others.
- R6: With adv=1 the cycle continues the current burst. The upper address bits stay those of the last load. On beat k (k=1..3, wrapping modulo 4), the low two bits are start+k mod 4 when ord_lin=1 and start XOR k when ord_lin=0. The read or write type and the accept decision come from the load, and wr_req and the chip selects are ignored.
- R7: While clk_en=0 at an edge, nothing advances. No write is stored, d_out and d_oe hold, and the inputs of that edge are ignored.
- R8: oe_n=1 forces d_oe=0 at once, without a clock edge.
- R9: sleep=1 forces d_oe=0 at once. A cycle sampled while sleep=1 is a deselect and ends any burst, so later advance cycles are deselects too. The array contents are kept.
- R10: A reset edge with rst=1 empties the pipeline, discards writes still waiting for data, and leaves d_oe=0.
- R11: In the output slot of a write cycle or a deselect cycle, d_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; 0 suspends the whole pipeline |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_req | input | 1 | 1 = write, 0 = read (load cycles only) |
| lane_wr | input | 4 | Per-lane write enables, active high |
| adv | input | 1 | 1 = continue burst, 0 = load a new address |
| ord_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down |
| addr | input | 8 | Word address |
| d_in | input | 36 | Write data, two edges after its address |
| d_out | output | 36 | Registered read data |
| d_oe | output | 1 | Output drive enable for the data bus |

## Verification
The hardest case to reach is a read that falls exactly one cycle behind a write to the same word, at the moment the write's data is still on the input and not yet in the array. Partial lane masks then decide which bytes must come from the input and which from the stored word. The stimulus writes and reads in tight alternation over a set of four addresses with random lane masks. It also runs bursts that write and then read back the same quad. Clock-enable gaps are mixed in to stretch this window over frozen cycles, and a reset is placed between two pending writes to show that their data is dropped.

// File: rtl/zt_pkg.sv
package zt_pkg;

    parameter int ZT_AW    = 8;
    parameter int ZT_LANES = 4;
    parameter int ZT_LW    = 9;

    localparam int ZT_DW    = ZT_LANES * ZT_LW;
    localparam int ZT_DEPTH = 1 << ZT_AW;
    localparam int ZT_BW    = 2;

    typedef logic [ZT_AW-1:0]    zt_addr_t;
    typedef logic [ZT_DW-1:0]    zt_data_t;
    typedef logic [ZT_LANES-1:0] zt_lane_t;

    typedef enum logic {
        ORD_INTLV = 1'b0,
        ORD_LIN   = 1'b1
    } zt_order_e;

    typedef struct packed {
        logic     vld;
        logic     wr;
        zt_addr_t addr;
        zt_lane_t be;
    } zt_op_t;

    // low address bits of a burst beat
    function automatic logic [ZT_BW-1:0] zt_burst_low(
        input logic [ZT_BW-1:0] start,
        input logic [ZT_BW-1:0] step,
        input zt_order_e        ord
    );
        return (ord == ORD_LIN) ? (start + step) : (start ^ step);
    endfunction

    // replace the selected lanes of a word
    function automatic zt_data_t zt_merge(
        input zt_data_t base,
        input zt_data_t upd,
        input zt_lane_t sel
    );
        zt_data_t r;
        r = base;
        for (int l = 0; l < ZT_LANES; l++) begin
            if (sel[l]) r[l*ZT_LW +: ZT_LW] = upd[l*ZT_LW +: ZT_LW];
        end
        return r;
    endfunction

endpackage

// File: rtl/zt_addr_stage.sv
module zt_addr_stage
    import zt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      sleep,
    input  logic      cs_ok,
    input  logic      wr_req,
    input  logic      adv,
    input  zt_order_e ord,
    input  zt_addr_t  addr,
    input  zt_lane_t  lane_wr,
    output zt_op_t    op_q
);

    zt_addr_t         base_q;
    logic [ZT_BW-1:0] step_q;
    logic [ZT_BW-1:0] step_nx;
    logic             bvld_q;
    logic             bwr_q;
    zt_addr_t         burst_addr;

    assign step_nx    = step_q + {{(ZT_BW-1){1'b0}}, 1'b1};
    assign burst_addr = {base_q[ZT_AW-1:ZT_BW],
                         zt_burst_low(base_q[ZT_BW-1:0], step_nx, ord)};

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            base_q <= '0;
            step_q <= '0;
            bvld_q <= 1'b0;
            bwr_q  <= 1'b0;
        end else if (en) begin
            if (sleep) begin
                op_q.vld <= 1'b0;
                op_q.be  <= '0;
                bvld_q   <= 1'b0;
            end else if (!adv) begin
                base_q <= addr;
                step_q <= '0;
                bvld_q <= cs_ok;
                bwr_q  <= wr_req;
                op_q   <= '{vld:  cs_ok,
                            wr:   wr_req,
                            addr: addr,
                            be:   (cs_ok && wr_req) ? lane_wr : '0};
            end else begin
                step_q <= step_nx;
                op_q   <= '{vld:  bvld_q,
                            wr:   bwr_q,
                            addr: burst_addr,
                            be:   (bvld_q && bwr_q) ? lane_wr : '0};
            end
        end
    end

    // R1
    desel_load_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !sleep && !adv && !cs_ok) |=> !op_q.vld);

    // R6
    burst_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !sleep && adv) |=>
            (op_q.addr[ZT_AW-1:ZT_BW] == $past(op_q.addr[ZT_AW-1:ZT_BW])));

endmodule

// File: rtl/zt_wpipe.sv
module zt_wpipe
    import zt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  zt_op_t   op1,
    input  zt_data_t d_in,
    output zt_op_t   op2,
    output zt_lane_t we,
    output zt_addr_t waddr,
    output zt_data_t wdata
);

    always_ff @(posedge clk) begin
        if (rst)     op2 <= '0;
        else if (en) op2 <= op1;
    end

    assign we    = (en && !rst && op2.vld && op2.wr) ? op2.be : '0;
    assign waddr = op2.addr;
    assign wdata = d_in;

    // R7
    wpipe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(op2));

    // R1
    no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !op1.vld) |=> (we == '0));

endmodule

// File: rtl/zt_array.sv
module zt_array
    import zt_pkg::*;
(
    input  logic     clk,
    input  zt_lane_t we,
    input  zt_addr_t waddr,
    input  zt_data_t wdata,
    input  zt_addr_t raddr,
    output zt_data_t rdata
);

    for (genvar l = 0; l < ZT_LANES; l++) begin : g_lane
        logic [ZT_LW-1:0] bank [ZT_DEPTH];

        always_ff @(posedge clk) begin
            if (we[l]) bank[waddr] <= wdata[l*ZT_LW +: ZT_LW];
        end

        assign rdata[l*ZT_LW +: ZT_LW] = bank[raddr];
    end

endmodule

// File: rtl/zt_rdpath.sv
module zt_rdpath
    import zt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     oe_n,
    input  logic     sleep,
    input  zt_op_t   op1,
    input  zt_op_t   op2,
    input  zt_data_t arr_q,
    input  zt_data_t d_in,
    output zt_data_t d_out,
    output logic     d_oe
);

    logic     rd_now;
    zt_lane_t fwd_sel;
    zt_data_t merged;
    logic     qv;
    zt_data_t q;

    assign rd_now  = op1.vld && !op1.wr;
    assign fwd_sel = (op2.vld && op2.wr && (op2.addr == op1.addr)) ? op2.be : '0;
    assign merged  = zt_merge(arr_q, d_in, fwd_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            qv <= 1'b0;
            q  <= '0;
        end else if (en) begin
            qv <= rd_now;
            if (rd_now) q <= merged;
        end
    end

    assign d_out = q;
    assign d_oe  = qv && !oe_n && !sleep;

    // R11
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op1.vld && op1.wr) |=> !d_oe);

    // R7
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(d_out));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_en,
    input  logic                sel_a,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                wr_req,
    input  logic [ZT_LANES-1:0] lane_wr,
    input  logic                adv,
    input  logic                ord_lin,
    input  logic                oe_n,
    input  logic                sleep,
    input  logic [ZT_AW-1:0]    addr,
    input  logic [ZT_DW-1:0]    d_in,
    output logic [ZT_DW-1:0]    d_out,
    output logic                d_oe
);

    logic     cs_ok;
    zt_op_t   op1;
    zt_op_t   op2;
    zt_lane_t we;
    zt_addr_t waddr;
    zt_data_t wdata;
    zt_data_t arr_q;

    assign cs_ok = sel_a && sel_b && !sel_c_n;

    zt_addr_stage u_addr (
        .clk     (clk),
        .rst     (rst),
        .en      (clk_en),
        .sleep   (sleep),
        .cs_ok   (cs_ok),
        .wr_req  (wr_req),
        .adv     (adv),
        .ord     (zt_order_e'(ord_lin)),
        .addr    (addr),
        .lane_wr (lane_wr),
        .op_q    (op1)
    );

    zt_wpipe u_wpipe (
        .clk   (clk),
        .rst   (rst),
        .en    (clk_en),
        .op1   (op1),
        .d_in  (d_in),
        .op2   (op2),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata)
    );

    zt_array u_array (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (op1.addr),
        .rdata (arr_q)
    );

    zt_rdpath u_rd (
        .clk   (clk),
        .rst   (rst),
        .en    (clk_en),
        .oe_n  (oe_n),
        .sleep (sleep),
        .op1   (op1),
        .op2   (op2),
        .arr_q (arr_q),
        .d_in  (d_in),
        .d_out (d_out),
        .d_oe  (d_oe)
    );

endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/100ps
module tb_zt_sram;
    import zt_pkg::*;

    localparam int AW = ZT_AW;
    localparam int LN = ZT_LANES;
    localparam int LW = ZT_LW;
    localparam int DW = ZT_DW;

    logic          clk = 1'b0;
    logic          rst, clk_en, sel_a, sel_b, sel_c_n, wr_req, adv, ord_lin, oe_n, sleep;
    logic [LN-1:0] lane_wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in;
    logic [DW-1:0] d_out;
    logic          d_oe;

    always #2.5 clk = ~clk;

    zt_sram dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .wr_req(wr_req), .lane_wr(lane_wr), .adv(adv),
        .ord_lin(ord_lin), .oe_n(oe_n), .sleep(sleep), .addr(addr),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    typedef struct {
        bit            v;
        bit            w;
        int            a;
        logic [LN-1:0] be;
    } mop_t;

    logic [DW-1:0] ref_mem [1<<AW];
    mop_t          hist[$];
    logic [DW-1:0] exp_q;
    bit            exp_drv;
    int            b_base, b_step;
    bit            b_v, b_w;
    int            vec, bad;
    string         req;
    bit            done;

    // behavioural reference, advanced on every clock edge
    always @(posedge clk) begin
        mop_t cur;
        if (rst) begin
            hist.delete();
            exp_drv = 1'b0;
            b_v = 1'b0; b_w = 1'b0; b_base = 0; b_step = 0;
        end else if (clk_en) begin
            cur.v = 1'b0; cur.w = 1'b0; cur.a = 0; cur.be = '0;
            if (sleep) begin
                b_v = 1'b0;
            end else if (!adv) begin
                b_base = int'(addr);
                b_step = 0;
                b_v    = sel_a && sel_b && !sel_c_n;
                b_w    = wr_req;
                cur.v = b_v; cur.w = b_w; cur.a = b_base; cur.be = lane_wr;
            end else begin
                b_step = (b_step + 1) % 4;
                cur.v  = b_v; cur.w = b_w; cur.be = lane_wr;
                cur.a  = (b_base & ~3) |
                         (ord_lin ? ((b_base + b_step) & 3) : ((b_base & 3) ^ b_step));
            end
            if (hist.size() == 2 && hist[0].v && hist[0].w) begin
                for (int l = 0; l < LN; l++)
                    if (hist[0].be[l]) ref_mem[hist[0].a][l*LW +: LW] = d_in[l*LW +: LW];
            end
            if (hist.size() > 0 && hist[$].v && !hist[$].w) begin
                exp_q   = ref_mem[hist[$].a];
                exp_drv = 1'b1;
            end else begin
                exp_drv = 1'b0;
            end
            if (hist.size() == 2) void'(hist.pop_front());
            hist.push_back(cur);
        end
    end

    task automatic chk_port();
        bit eo;
        eo = exp_drv && !oe_n && !sleep;
        vec++;
        if (d_oe !== eo) begin
            bad++;
            $display("FAIL %s d_oe=%b expected %b at %0t", req, d_oe, eo, $time);
        end else if (eo && d_out !== exp_q) begin
            bad++;
            $display("FAIL %s d_out=%h expected %h at %0t", req, d_out, exp_q, $time);
        end
    endtask

    // one cycle: check at the falling edge, then drive the next inputs
    task automatic cyc(input bit w, input int a, input logic [LN-1:0] be,
                       input bit ad, input logic [2:0] cs = 3'b110,
                       input bit ce = 1'b1, input bit slp = 1'b0,
                       input bit oe = 1'b0, input bit rs = 1'b0);
        logic [63:0] r64;
        @(negedge clk);
        chk_port();
        r64     = {$urandom(), $urandom()};
        wr_req  = w;
        addr    = a[AW-1:0];
        lane_wr = be;
        adv     = ad;
        {sel_a, sel_b, sel_c_n} = cs;
        clk_en  = ce;
        sleep   = slp;
        oe_n    = oe;
        rst     = rs;
        d_in    = r64[DW-1:0];
    endtask

    task automatic async_probe(input bit use_sleep, input string tag);
        @(posedge clk);
        #1;
        if (use_sleep) sleep = 1'b1; else oe_n = 1'b1;
        #0.5;
        vec++;
        if (d_oe !== 1'b0) begin
            bad++;
            $display("FAIL %s async d_oe=%b expected 0 at %0t", tag, d_oe, $time);
        end
        if (use_sleep) sleep = 1'b0; else oe_n = 1'b0;
    endtask

    function automatic logic [LN-1:0] rbe();
        logic [31:0] r;
        r = $urandom();
        return r[LN-1:0];
    endfunction

    function automatic logic [2:0] rcs();
        logic [31:0] r;
        r = $urandom();
        return r[2:0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: still running after %0d cycles, expected completion", 200000);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        vec = 0; bad = 0; done = 1'b0;
        rst = 1'b1; clk_en = 1'b1; sel_a = 1'b0; sel_b = 1'b0; sel_c_n = 1'b1;
        wr_req = 1'b0; adv = 1'b0; ord_lin = 1'b1; oe_n = 1'b0; sleep = 1'b0;
        lane_wr = '0; addr = '0; d_in = '0;
        repeat (3) @(posedge clk);

        // R10: reset state
        req = "R10";
        @(negedge clk);
        chk_port();
        rst = 1'b0;

        // R3: fill every word through all lanes
        req = "R3";
        for (int a = 0; a < (1 << AW); a++) cyc(1'b1, a, '1, 1'b0);
        repeat (2) cyc(1'b0, 0, '0, 1'b0, 3'b000);

        // R2: isolated and back-to-back reads
        req = "R2";
        for (int i = 0; i < 40; i++) cyc(1'b0, int'($urandom() % 256), '0, 1'b0);
        repeat (2) cyc(1'b0, 0, '0, 1'b0, 3'b000);

        // R4: partial lane writes with reads
        req = "R4";
        for (int i = 0; i < 80; i++)
            cyc(($urandom() % 2) == 1, int'($urandom() % 16), rbe(), 1'b0);

        // R5: tight alternation over four words, forwarding of pending data
        req = "R5";
        for (int i = 0; i < 60; i++) begin
            int a;
            a = int'($urandom() % 4);
            cyc(1'b1, a, rbe(), 1'b0);
            cyc(1'b0, a, '0, 1'b0);
            if (i % 3 == 0) begin
                cyc(1'b1, a, rbe(), 1'b0);
                cyc(1'b1, a, rbe(), 1'b0);
                cyc(1'b0, a, '0, 1'b0);
            end
        end

        // R6: bursts in both orders, ignored type and selects on advance
        req = "R6";
        for (int o = 0; o < 2; o++) begin
            for (int b = 0; b < 8; b++) begin
                int a;
                a = int'($urandom() % 256);
                @(negedge clk); ord_lin = (o == 1);
                cyc(b % 2 == 0, a, rbe(), 1'b0, (b == 7) ? 3'b010 : 3'b110);
                for (int k = 0; k < 5; k++)
                    cyc(($urandom() % 2) == 1, int'($urandom() % 256), rbe(), 1'b1, rcs());
                cyc(1'b0, a, '0, 1'b0);
                for (int k = 0; k < 3; k++) cyc(1'b1, 0, '0, 1'b1, 3'b000);
            end
        end

        // R1: chip select combinations
        req = "R1";
        for (int i = 0; i < 100; i++)
            cyc(($urandom() % 2) == 1, int'($urandom() % 16), rbe(), 1'b0, rcs());

        // R11: writes and deselects interleaved with reads
        req = "R11";
        for (int i = 0; i < 40; i++) begin
            cyc(1'b0, int'($urandom() % 16), '0, 1'b0);
            cyc(1'b1, int'($urandom() % 16), rbe(), 1'b0);
            cyc(1'b0, int'($urandom() % 16), '0, 1'b0, 3'b100);
        end

        // R7: clock suspend at random
        req = "R7";
        for (int i = 0; i < 150; i++)
            cyc(($urandom() % 2) == 1, int'($urandom() % 8), rbe(),
                ($urandom() % 3) == 0, 3'b110, ($urandom() % 2) == 1);

        // R8: output enable, including mid-cycle changes
        req = "R8";
        for (int i = 0; i < 40; i++) begin
            cyc(1'b0, int'($urandom() % 256), '0, 1'b0, 3'b110, 1'b1, 1'b0,
                ($urandom() % 3) == 0);
            if (i % 5 == 2) async_probe(1'b0, "R8");
        end

        // R9: sleep, including advance after sleep and mid-cycle entry
        req = "R9";
        for (int i = 0; i < 60; i++) begin
            cyc(($urandom() % 3) == 0, int'($urandom() % 8), rbe(),
                ($urandom() % 2) == 1, 3'b110, 1'b1, ($urandom() % 4) == 0);
            if (i % 6 == 3) async_probe(1'b1, "R9");
        end
        for (int a = 0; a < 8; a++) cyc(1'b0, a, '0, 1'b0);

        // R10: reset between pending writes discards them
        req = "R10";
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 20, '1, 1'b0);
            cyc(1'b1, 21, '1, 1'b0, 3'b110, 1'b1, 1'b0, 1'b0, 1'b1);
            cyc(1'b0, 20, '0, 1'b0);
            cyc(1'b0, 21, '0, 1'b0);
            cyc(1'b0, 0, '0, 1'b0, 3'b000);
        end

        // mixed traffic touching all requirements (R5 R6 R7 R9)
        req = "R5";
        for (int i = 0; i < 1500; i++)
            cyc(($urandom() % 2) == 1, int'($urandom() % 12), rbe(),
                ($urandom() % 5) < 2, (($urandom() % 8) == 0) ? rcs() : 3'b110,
                ($urandom() % 5) != 0, ($urandom() % 12) == 0,
                ($urandom() % 10) == 0);

        repeat (3) cyc(1'b0, 0, '0, 1'b0, 3'b000);
        @(negedge clk);
        chk_port();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule